// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with a small memory-mapped register set. A slow reference clock is brought into the system clock domain and divided down to one of four tick rates. Each tick advances an 8-bit up-counter. The counter stops at its maximum value and does not wrap. When the counter steps onto a programmable interrupt threshold, the block latches an interrupt status bit. When it steps onto a second programmable threshold, the block raises a reset request that stays high until the block itself is reset.

Software keeps the timer alive by writing an exact 8-bit restart key. A different exact key locks the timer. Once locked, the timer runs unconditionally and its configuration can no longer be changed. The bus fabric, the interrupt controller and the chip reset generator sit outside this block. It connects to them through a single-cycle write strobe, a combinational read data bus, an interrupt line and a reset-request line.

Top module: `wdk_top`

## Requirements
- R1: After `rst_ni` is released, the count reads 0, the configuration word reads 0, the interrupt status reads 0, and both `irq_o` and `rst_req_o` are 0.
- R2: The configuration word at offset 0x000 has these fields: run enable at bit 0, interrupt-capture enable at bit 1, reset-request enable at bit 2, reset threshold at bits 15:8, interrupt threshold at bits 23:16, and rate select at bits 26:24. All other bits read 0.
- R3: The reference clock is nominally 256 Hz. Each rate select code advances the counter once per a fixed number of reference rising edges, counted from the last restart: code 1 every 2 edges, code 2 every 16, code 3 every 256, and code 4 every 4096. Codes 0, 5, 6 and 7 never advance the counter.
- R4: While the run enable is 0, the counter does not advance.
- R5: A write to offset 0x004 whose low byte is 0xB2 clears the counter and the tick divider to 0. A write with any other low byte leaves the count unchanged.
- R6: The counter stops at 0xFF and stays there while ticks continue.
- R7: On the tick that moves the count onto the interrupt threshold, the interrupt status (offset 0x204, bit 0) is set, but only if interrupt-capture enable is 1. Once set, it stays set.
- R8: `irq_o` equals the interrupt status ANDed with bit 0 of the interrupt enable register at offset 0x200.
- R9: Writing 1 to bit 0 at offset 0x208 clears the interrupt status. Writing 1 to bit 0 at offset 0x20C sets it.
- R10: If reset-request enable is 1, the tick that moves the count onto the reset threshold raises `rst_req_o`. It stays high, even through restarts, until `rst_ni` is asserted.
- R11: A write to offset 0x008 whose low byte is 0x3A locks the timer. The run enable is then forced to 1 and all later configuration writes are ignored. Other lock values do nothing. Only `rst_ni` removes the lock.
- R12: The current count reads at offset 0x00C, in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The bench goes after the tick divider at every select code, including the undefined ones. A divider that is not cleared by a restart, or that gives the undefined codes a rate, shows up as a wrong count. It drives the counter past 0xFF, where a design that wraps would report a small value, and it crosses the interrupt threshold twice. A level-style compare or a missing capture gate would then re-set a cleared status, or set it while capture is disabled. It also probes keys that are off by one bit and configuration writes made after locking. A design that matched a key loosely, or let the lock be undone, would either restart or lock when it should not, or change a frozen configuration.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_CFG     = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_KICK    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LOCK    = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_COUNT   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_IE      = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 12'h204;
  localparam logic [ADDR_W-1:0] OFS_CLR     = 12'h208;
  localparam logic [ADDR_W-1:0] OFS_SET     = 12'h20C;

  localparam logic [7:0] KICK_KEY = 8'hB2;
  localparam logic [7:0] LOCK_KEY = 8'h3A;

  typedef enum logic [SEL_W-1:0] {
    RATE_OFF  = 3'd0,
    RATE_FAST = 3'd1,
    RATE_MID  = 3'd2,
    RATE_SEC  = 3'd3,
    RATE_SLOW = 3'd4
  } rate_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] irq_thr;
    logic [CNT_W-1:0] rst_thr;
    logic             rst_en;
    logic             irq_en;
    logic             run;
  } cfg_t;

  function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[0]     = c.run;
    w[1]     = c.irq_en;
    w[2]     = c.rst_en;
    w[15:8]  = c.rst_thr;
    w[23:16] = c.irq_thr;
    w[26:24] = c.sel;
    return w;
  endfunction

  function automatic cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
    cfg_t c;
    c.run     = w[0];
    c.irq_en  = w[1];
    c.rst_en  = w[2];
    c.rst_thr = w[15:8];
    c.irq_thr = w[23:16];
    c.sel     = w[26:24];
    return c;
  endfunction

  // True for the four select codes that define a tick rate.
  function automatic logic rate_valid(input logic [SEL_W-1:0] sel);
    return (sel >= 3'(RATE_FAST)) && (sel <= 3'(RATE_SLOW));
  endfunction

  // log2 of reference edges per tick; ref_log2 is log2 of the reference rate.
  function automatic int rate_shift(input logic [SEL_W-1:0] sel, input int ref_log2);
    case (sel)
      3'(RATE_FAST): return ref_log2 - 7;
      3'(RATE_MID):  return ref_log2 - 4;
      3'(RATE_SEC):  return ref_log2;
      3'(RATE_SLOW): return ref_log2 + 4;
      default:       return 0;
    endcase
  endfunction

  // Counter step that stops at the top value.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/wdk_tickgen.sv
module wdk_tickgen
  import wdk_pkg::*;
#(
  parameter int REF_LOG2 = 8,   // reference clock is 2**REF_LOG2 Hz, at least 128 Hz
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             tick_o
);

  localparam int PRE_W = REF_LOG2 + 4;

  logic [SYNC_STAGES:0] sync_q;
  logic                 ref_edge;
  logic [PRE_W-1:0]     pre_q;
  logic [PRE_W-1:0]     pre_mask;
  logic                 active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ref_clk_i};
  end

  assign ref_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign active   = run_i & rate_valid(sel_i);

  always_comb begin
    pre_mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < rate_shift(sel_i, REF_LOG2)) pre_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || !active) pre_q <= '0;
    else if (ref_edge)            pre_q <= pre_q + 1'b1;
  end

  assign tick_o = active && ref_edge && ((pre_q & pre_mask) == pre_mask);

  // Two synchronized rising edges are always separated by at least one low cycle.
  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // An undefined or zero select code never produces a tick.
  assert_bad_sel_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rate_valid(sel_i) |-> !tick_o);

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
  import wdk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] irq_thr_i,
  input  logic [CNT_W-1:0] rst_thr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_hit_o,
  output logic             rst_hit_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_nx;
  logic             step;

  assign count_nx = sat_inc(count_q);
  assign step     = tick_i && !restart_i && !(&count_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (restart_i) count_q <= '0;
    else if (tick_i)    count_q <= count_nx;
  end

  // A hit is an arrival: only a real step onto the threshold counts.
  assign irq_hit_o = step && (count_nx == irq_thr_i);
  assign rst_hit_o = step && (count_nx == rst_thr_i);
  assign count_o   = count_q;

  assert_restart_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> count_q == '0);

  assert_hold_at_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&count_q) && !restart_i |=> (&count_q));

  assert_idle_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !restart_i |=> $stable(count_q));

endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              irq_hit_i,
  input  logic              rst_hit_i,
  output cfg_t              cfg_o,
  output logic              restart_o,
  output logic              irq_o,
  output logic              rst_req_o
);

  cfg_t cfg_q;
  logic locked_q;
  logic ie_q;
  logic stat_q;
  logic rst_req_q;

  logic wr_cfg, wr_kick, wr_lock, wr_ie, wr_clr, wr_set;
  logic lock_now, capture;

  assign wr_cfg  = we_i && (addr_i == OFS_CFG);
  assign wr_kick = we_i && (addr_i == OFS_KICK);
  assign wr_lock = we_i && (addr_i == OFS_LOCK);
  assign wr_ie   = we_i && (addr_i == OFS_IE);
  assign wr_clr  = we_i && (addr_i == OFS_CLR) && wdata_i[0];
  assign wr_set  = we_i && (addr_i == OFS_SET) && wdata_i[0];

  assign restart_o = wr_kick && (wdata_i[7:0] == KICK_KEY);
  assign lock_now  = wr_lock && (wdata_i[7:0] == LOCK_KEY);
  assign capture   = irq_hit_i && cfg_q.irq_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (lock_now) begin
      locked_q   <= 1'b1;
      cfg_q.run  <= 1'b1;
    end else if (wr_cfg && !locked_q) begin
      cfg_q <= word_to_cfg(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q      <= 1'b0;
      stat_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (wr_ie) ie_q <= wdata_i[0];
      // An event or a software set in the same cycle as a clear wins.
      if (capture || wr_set) stat_q <= 1'b1;
      else if (wr_clr)       stat_q <= 1'b0;
      if (rst_hit_i && cfg_q.rst_en) rst_req_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CFG:   rdata_o = cfg_to_word(cfg_q);
      OFS_COUNT: rdata_o[CNT_W-1:0] = count_i;
      OFS_IE:    rdata_o[0] = ie_q;
      OFS_STAT:  rdata_o[0] = stat_q;
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign irq_o     = stat_q & ie_q;
  assign rst_req_o = rst_req_q;

  assert_lock_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);

  assert_lock_runs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> cfg_q.run);

  assert_lock_freezes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q && !lock_now |=> $stable(cfg_q));

  assert_rst_req_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> rst_req_q);

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_q);

  assert_status_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q && !irq_hit_i && !wr_set |=> !stat_q);

endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int REF_LOG2    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);

  cfg_t             cfg;
  logic             restart;
  logic             tick;
  logic [CNT_W-1:0] count;
  logic             irq_hit;
  logic             rst_hit;

  wdk_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .count_i   (count),
    .irq_hit_i (irq_hit),
    .rst_hit_i (rst_hit),
    .cfg_o     (cfg),
    .restart_o (restart),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  wdk_tickgen #(
    .REF_LOG2    (REF_LOG2),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .run_i     (cfg.run),
    .sel_i     (cfg.sel),
    .restart_i (restart),
    .tick_o    (tick)
  );

  wdk_counter u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .restart_i (restart),
    .irq_thr_i (cfg.irq_thr),
    .rst_thr_i (cfg.rst_thr),
    .count_o   (count),
    .irq_hit_o (irq_hit),
    .rst_hit_o (rst_hit)
  );

  assert_stopped_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.run && !restart |=> $stable(count));

  assert_req_needs_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(cfg.rst_en));

endmodule

// File: tb/wdk_top_test.sv
module wdk_top_test;
  import wdk_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refc = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rreq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wdk_top uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(refc),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .rst_req_o(rreq)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] edges;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 16'd10}, '{3'd1, 16'd3},  '{3'd2, 16'd40},
    '{3'd3, 16'd300}, '{3'd4, 16'd4100}, '{3'd0, 16'd10},
    '{3'd5, 16'd10}, '{3'd6, 16'd10}, '{3'd7, 16'd10}
  };

  // Edges per tick for each select code, written out from R3.
  function automatic int per_tick(input logic [2:0] s);
    case (s)
      3'd1: return 2;
      3'd2: return 16;
      3'd3: return 256;
      3'd4: return 4096;
      default: return 0;
    endcase
  endfunction

  function automatic int expect_count(input logic [2:0] s, input int e);
    int v;
    if (per_tick(s) == 0) return 0;
    v = e / per_tick(s);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      refc = 1'b1;
      repeat (4) @(negedge clk);
      refc = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] cfgw(input logic [2:0] s, input logic [7:0] ithr,
                                       input logic [7:0] rthr, input logic re,
                                       input logic ie, input logic en);
    return {5'd0, s, ithr, rthr, 5'd0, re, ie, en};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();

    // R1 reset state
    rd(OFS_COUNT, r); check("R1 count", r, 32'h0);
    rd(OFS_CFG, r);   check("R1 cfg", r, 32'h0);
    rd(OFS_STAT, r);  check("R1 status", r, 32'h0);
    check("R1 irq/rst_req", {30'd0, irq, rreq}, 32'h0);

    // R2 field layout and unused bits
    wr(OFS_CFG, 32'hFFFF_FFF8);
    rd(OFS_CFG, r); check("R2 mask", r, 32'h07FF_FF00);
    wr(OFS_CFG, cfgw(3'd4, 8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0));
    rd(OFS_CFG, r); check("R2 fields", r, 32'h045A_C302);

    // R3 rate table, walked by one loop
    foreach (VECS[i]) begin
      wr(OFS_CFG, cfgw(VECS[i].sel, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1));
      wr(OFS_KICK, 32'hB2);
      pulses(int'(VECS[i].edges));
      rd(OFS_COUNT, r);
      check($sformatf("R3 sel %0d", VECS[i].sel), r,
            32'(expect_count(VECS[i].sel, int'(VECS[i].edges))));
    end

    // R4 stopped timer
    wr(OFS_CFG, cfgw(3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0));
    wr(OFS_KICK, 32'hB2);
    pulses(8);
    rd(OFS_COUNT, r); check("R4 disabled", r, 32'h0);

    // R5 keys: wrong key ignored, key judged on low byte only
    wr(OFS_CFG, cfgw(3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1));
    pulses(8);
    wr(OFS_KICK, 32'hB3);
    rd(OFS_COUNT, r); check("R5 wrong key", r, 32'd4);
    wr(OFS_KICK, 32'h0000_01B2);
    rd(OFS_COUNT, r); check("R5 restart", r, 32'd0);
    pulses(1);
    rd(OFS_COUNT, r); check("R5 divider cleared", r, 32'd0);

    // R6 saturation (R12 read path)
    wr(OFS_KICK, 32'hB2);
    pulses(520);
    rd(OFS_COUNT, r); check("R6 R12 top", r, 32'hFF);

    // R7 / R8 / R9 interrupt path
    wr(OFS_IE, 32'h1);
    wr(OFS_CFG, cfgw(3'd1, 8'd3, 8'd0, 1'b0, 1'b1, 1'b1));
    wr(OFS_KICK, 32'hB2);
    pulses(4);
    rd(OFS_STAT, r); check("R7 before thr", r, 32'h0);
    pulses(2);
    rd(OFS_STAT, r); check("R7 at thr", r, 32'h1);
    check("R8 irq on", {31'd0, irq}, 32'h1);
    wr(OFS_IE, 32'h0);
    check("R8 irq masked", {31'd0, irq}, 32'h0);
    wr(OFS_CLR, 32'h1);
    pulses(4);
    rd(OFS_STAT, r); check("R9 clear no refire", r, 32'h0);
    wr(OFS_SET, 32'h1);
    rd(OFS_STAT, r); check("R9 set", r, 32'h1);
    wr(OFS_CLR, 32'h1);
    wr(OFS_CFG, cfgw(3'd1, 8'd3, 8'd0, 1'b0, 1'b0, 1'b1));
    wr(OFS_KICK, 32'hB2);
    pulses(8);
    rd(OFS_STAT, r); check("R7 capture off", r, 32'h0);

    // R10 reset request
    wr(OFS_CFG, cfgw(3'd1, 8'd0, 8'd4, 1'b0, 1'b0, 1'b1));
    wr(OFS_KICK, 32'hB2);
    pulses(10);
    check("R10 disabled", {31'd0, rreq}, 32'h0);
    wr(OFS_CFG, cfgw(3'd1, 8'd0, 8'd4, 1'b1, 1'b0, 1'b1));
    wr(OFS_KICK, 32'hB2);
    pulses(6);
    check("R10 before thr", {31'd0, rreq}, 32'h0);
    pulses(2);
    check("R10 at thr", {31'd0, rreq}, 32'h1);
    wr(OFS_KICK, 32'hB2);
    check("R10 sticky", {31'd0, rreq}, 32'h1);
    do_reset();
    check("R10 cleared by reset", {31'd0, rreq}, 32'h0);

    // R11 lock
    wr(OFS_CFG, cfgw(3'd1, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    wr(OFS_LOCK, 32'h3B);
    wr(OFS_CFG, cfgw(3'd2, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    rd(OFS_CFG, r); check("R11 wrong key", r, 32'h0200_0000);
    wr(OFS_CFG, cfgw(3'd1, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    wr(OFS_LOCK, 32'h3A);
    rd(OFS_CFG, r); check("R11 forced run", r, 32'h0100_0001);
    wr(OFS_CFG, 32'h0);
    rd(OFS_CFG, r); check("R11 frozen", r, 32'h0100_0001);
    wr(OFS_KICK, 32'hB2);
    pulses(6);
    rd(OFS_COUNT, r); check("R11 runs locked", r, 32'd3);
    do_reset();
    wr(OFS_CFG, 32'h0);
    rd(OFS_CFG, r); check("R11 unlocked by reset", r, 32'h0);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule